// File: doc/BRIEF.md
# RTC Alarm Interrupt Output Controller

This block drives the active-low interrupt pin and the alarm status bit of a real-time clock. It does not compare times. An external comparator raises a one-cycle match pulse when the alarm time is reached, and this block decides what that match does. The match is ignored unless the alarm is enabled and the frequency output function is off.

Software picks one of two pin behaviours with a mode bit. In standard mode, meant for a single alarm event, the pin goes low on a match and stays low until software clears the status bit. In interrupt mode, meant for a recurring alarm, each match gives a low pulse of fixed width on the pin. The width is counted in ticks of a 32768 Hz timebase enable, and the default of 8192 ticks gives 250 ms. A match that arrives while a pulse is running restarts the pulse.

All state is held in flops on one clock. The pin is registered, so every effect shows on the outputs one clock after the edge that samples its cause.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, `irqN` is 1 and `almStatus` is 0.
- R2: While `almEnable` is 0, a `matchPulse` has no effect: `almStatus` keeps its value and `irqN` stays 1.
- R3: While `freqOutOn` is 1, a `matchPulse` has no effect: `almStatus` keeps its value and `irqN` stays 1.
- R4: An accepted match sets `almStatus` to 1 one cycle later, in either mode. A match is accepted when `matchPulse` is 1, `almEnable` is 1 and `freqOutOn` is 0.
- R5: `statusClear` clears `almStatus` one cycle later when no match is accepted in that cycle. When a match is accepted in the same cycle, the status stays 1. With neither a match nor a clear, the status holds its value.
- R6: In standard mode (`intMode` = 0), `irqN` is 0 from the cycle after an accepted match for as long as `almStatus` is 1 and the alarm is active. It returns to 1 in the cycle after the status is cleared.
- R7: In interrupt mode (`intMode` = 1), `irqN` goes 0 in the cycle after an accepted match. It returns to 1 in the cycle after the edge that samples the PULSE_TICKS-th `tickEn` following that match. A `tickEn` sampled together with the match is not counted. In this mode `irqN` does not depend on `almStatus`.
- R8: In interrupt mode, an accepted match during a running pulse restarts the count, so a full PULSE_TICKS ticks are needed after it.
- R9: Dropping `almEnable` or raising `freqOutOn` sets `irqN` to 1 one cycle later. Any running pulse is abandoned and does not resume when the alarm becomes active again. `almStatus` is kept. In standard mode the pin goes low again once the alarm is active while the status is still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| almEnable | input | 1 | Alarm function enable |
| intMode | input | 1 | 1 = pulse per match, 0 = level held until cleared |
| freqOutOn | input | 1 | Frequency output active; suppresses the alarm path |
| matchPulse | input | 1 | One-cycle alarm match from the comparator |
| statusClear | input | 1 | Software clear of the status bit |
| tickEn | input | 1 | 32768 Hz timebase enable, one cycle wide |
| almStatus | output | 1 | Alarm status bit |
| irqN | output | 1 | Interrupt pin, active low |

## Verification
Both outputs are flops loaded from the same edge. A match, clear or disable sampled at one edge therefore shows on `almStatus` and `irqN` just after that edge, and on no later edge. The bench drives every input at the falling edge and reads the outputs at the next falling edge, so each check lands half a period after the edge that causes it. Pulse-width checks are made once per cycle. The bench keeps its own running count of the ticks it has driven since the last match, and the expected pin value in each cycle is simply whether that count has reached PULSE_TICKS. This is repeated for several tick spacings.

// File: rtl/rtc_alarm_irq_pkg.sv
package rtc_alarm_irq_pkg;

  // Strobes from the control decode to the state-holding datapath
  typedef struct packed {
    logic setStatus;   // accepted match: status becomes 1
    logic clrStatus;   // software clear with no competing match
    logic loadPulse;   // start or restart the pulse counter
    logic abortPulse;  // alarm path inactive: zero the counter
    logic countTick;   // consume one timebase tick
    logic selPulse;    // pin follows the pulse (1) or the status (0)
    logic pinEnable;   // pin may be driven low at all
  } alarmCtrl_t;

endpackage

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import rtc_alarm_irq_pkg::*;
(
  input  logic       almEnable,
  input  logic       intMode,
  input  logic       freqOutOn,
  input  logic       matchPulse,
  input  logic       statusClear,
  input  logic       tickEn,
  input  logic       pulseBusy,
  output alarmCtrl_t ctrl
);

  logic pathActive;
  logic matchTaken;

  // The frequency output function takes priority over the alarm
  assign pathActive = almEnable & ~freqOutOn;
  assign matchTaken = matchPulse & pathActive;

  always_comb begin
    ctrl            = '0;
    ctrl.setStatus  = matchTaken;
    ctrl.clrStatus  = statusClear & ~matchTaken;
    ctrl.loadPulse  = matchTaken & intMode;
    ctrl.abortPulse = ~pathActive;
    // a tick in the same cycle as a reload is not counted
    ctrl.countTick  = tickEn & pulseBusy & ~(matchTaken & intMode);
    ctrl.selPulse   = intMode;
    ctrl.pinEnable  = pathActive;
  end

endmodule

// File: rtl/alarm_irq_datapath.sv
module alarm_irq_datapath
  import rtc_alarm_irq_pkg::*;
#(
  parameter int PULSE_TICKS = 8192
) (
  input  logic       clk,
  input  logic       rstN,
  input  alarmCtrl_t ctrl,
  output logic       pulseBusy,
  output logic       almStatus,
  output logic       irqN
);

  localparam int CNT_W = $clog2(PULSE_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_TICKS);

  logic [CNT_W-1:0] pulseCnt;
  logic [CNT_W-1:0] pulseCntNext;
  logic             statusNext;
  logic             busyNext;
  logic             irqNNext;

  always_comb begin
    statusNext = almStatus;
    if (ctrl.setStatus) begin
      statusNext = 1'b1;
    end else if (ctrl.clrStatus) begin
      statusNext = 1'b0;
    end
  end

  always_comb begin
    pulseCntNext = pulseCnt;
    if (ctrl.abortPulse) begin
      pulseCntNext = '0;
    end else if (ctrl.loadPulse) begin
      pulseCntNext = CNT_LOAD;
    end else if (ctrl.countTick) begin
      pulseCntNext = pulseCnt - 1'b1;
    end
  end

  assign busyNext = (pulseCntNext != '0);

  // The pin is registered from the next-state values, so it moves on the same
  // edge as the status bit
  always_comb begin
    irqNNext = 1'b1;
    if (ctrl.pinEnable) begin
      irqNNext = ctrl.selPulse ? ~busyNext : ~statusNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      almStatus <= 1'b0;
      pulseCnt  <= '0;
      irqN      <= 1'b1;
    end else begin
      almStatus <= statusNext;
      pulseCnt  <= pulseCntNext;
      irqN      <= irqNNext;
    end
  end

  assign pulseBusy = (pulseCnt != '0);

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_irq_pkg::*;
#(
  parameter int PULSE_TICKS = 8192
) (
  input  logic clk,
  input  logic rstN,
  input  logic almEnable,
  input  logic intMode,
  input  logic freqOutOn,
  input  logic matchPulse,
  input  logic statusClear,
  input  logic tickEn,
  output logic almStatus,
  output logic irqN
);

  alarmCtrl_t ctrl;
  logic       pulseBusy;

  alarm_irq_ctrl u_ctrl (
    .almEnable  (almEnable),
    .intMode    (intMode),
    .freqOutOn  (freqOutOn),
    .matchPulse (matchPulse),
    .statusClear(statusClear),
    .tickEn     (tickEn),
    .pulseBusy  (pulseBusy),
    .ctrl       (ctrl)
  );

  alarm_irq_datapath #(
    .PULSE_TICKS(PULSE_TICKS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .pulseBusy(pulseBusy),
    .almStatus(almStatus),
    .irqN     (irqN)
  );

endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk (
  input logic clk,
  input logic rstN,
  input logic almEnable,
  input logic intMode,
  input logic freqOutOn,
  input logic matchPulse,
  input logic statusClear,
  input logic almStatus,
  input logic irqN
);

  logic taken;
  assign taken = matchPulse & almEnable & ~freqOutOn;

  assert_inactive_pin_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!almEnable || freqOutOn) |=> irqN);

  assert_disabled_match_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!almEnable && !statusClear) |=> $stable(almStatus));

  assert_freqout_match_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (freqOutOn && !statusClear) |=> $stable(almStatus));

  assert_status_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    taken |=> almStatus);

  assert_status_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statusClear && !taken) |=> !almStatus);

  assert_status_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!statusClear && !taken) |=> $stable(almStatus));

  assert_level_follows_status_R6: assert property (@(posedge clk) disable iff (!rstN)
    (almEnable && !freqOutOn && !intMode) |=> (irqN == !almStatus));

  assert_pulse_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    (taken && intMode) |=> !irqN);

endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .almEnable  (almEnable),
  .intMode    (intMode),
  .freqOutOn  (freqOutOn),
  .matchPulse (matchPulse),
  .statusClear(statusClear),
  .almStatus  (almStatus),
  .irqN       (irqN)
);

// File: tb/rtc_alarm_irq_tb.sv
`timescale 1ns/1ps
module rtc_alarm_irq_tb;

  localparam int P = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic almEnable = 1'b0;
  logic intMode = 1'b0;
  logic freqOutOn = 1'b0;
  logic matchPulse = 1'b0;
  logic statusClear = 1'b0;
  logic tickEn = 1'b0;
  logic almStatus;
  logic irqN;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rtc_alarm_irq #(.PULSE_TICKS(P)) u_dut (
    .clk(clk), .rstN(rstN), .almEnable(almEnable), .intMode(intMode),
    .freqOutOn(freqOutOn), .matchPulse(matchPulse), .statusClear(statusClear),
    .tickEn(tickEn), .almStatus(almStatus), .irqN(irqN)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge: drive inputs, pass one rising edge, return at the next falling edge
  task automatic cyc(input logic m, input logic clr, input logic tk);
    matchPulse = m; statusClear = clr; tickEn = tk;
    @(posedge clk);
    @(negedge clk);
    matchPulse = 1'b0; statusClear = 1'b0; tickEn = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int ticks;
    repeat (3) @(negedge clk);
    chk(irqN, 1'b1, "R1 pin");
    chk(almStatus, 1'b0, "R1 status");
    rstN = 1'b1;
    cyc(0, 0, 0);
    chk(irqN, 1'b1, "R1 pin after reset release");

    // R2: disabled alarm ignores a match
    almEnable = 0; intMode = 0;
    cyc(1, 0, 0);
    chk(almStatus, 1'b0, "R2 status");
    chk(irqN, 1'b1, "R2 pin");

    // R3: frequency output suppresses a match
    almEnable = 1; freqOutOn = 1;
    cyc(1, 0, 0);
    chk(almStatus, 1'b0, "R3 status");
    chk(irqN, 1'b1, "R3 pin");
    freqOutOn = 0;

    // R4/R6: standard mode
    cyc(1, 0, 0);
    chk(almStatus, 1'b1, "R4 status set std");
    chk(irqN, 1'b0, "R6 pin low");
    for (int i = 0; i < 6; i++) begin
      cyc(0, 0, 1);
      chk(irqN, 1'b0, "R6 pin held");
    end
    // R5: clear together with a match keeps the status
    cyc(1, 1, 0);
    chk(almStatus, 1'b1, "R5 match beats clear");
    chk(irqN, 1'b0, "R6 pin still low");
    cyc(0, 1, 0);
    chk(almStatus, 1'b0, "R5 clear");
    chk(irqN, 1'b1, "R6 release on clear");

    // R9: disable during the low level, status kept, level returns
    cyc(1, 0, 0);
    almEnable = 0;
    cyc(0, 0, 0);
    chk(irqN, 1'b1, "R9 disable releases pin");
    chk(almStatus, 1'b1, "R9 status kept");
    almEnable = 1;
    cyc(0, 0, 0);
    chk(irqN, 1'b0, "R9 level resumes");
    freqOutOn = 1;
    cyc(0, 0, 0);
    chk(irqN, 1'b1, "R9 freq out releases pin");
    freqOutOn = 0;
    cyc(0, 1, 0);
    chk(almStatus, 1'b0, "R5 clear again");

    // R7: interrupt mode sweep over tick spacings
    intMode = 1;
    for (int n = 1; n <= 3; n++) begin
      cyc(1, 0, 1);
      chk(irqN, 1'b0, "R7 pulse start");
      chk(almStatus, 1'b1, "R4 status set int");
      ticks = 0;
      for (int j = 0; j < P * n + 2; j++) begin
        logic tk;
        tk = ((j % n) == n - 1);
        cyc(0, 0, tk);
        if (tk) ticks++;
        chk(irqN, (ticks >= P) ? 1'b1 : 1'b0, "R7 pulse width");
      end
      chk(almStatus, 1'b1, "R7 status independent of pin");
      cyc(0, 1, 0);
      chk(almStatus, 1'b0, "R5 clear int");
      chk(irqN, 1'b1, "R7 pin unaffected by clear");
    end

    // R8: retrigger in the middle of a pulse
    cyc(1, 0, 0);
    cyc(0, 0, 1);
    cyc(0, 0, 1);
    cyc(1, 0, 1);
    chk(irqN, 1'b0, "R8 retriggered");
    for (int j = 1; j <= P; j++) begin
      cyc(0, 0, 1);
      chk(irqN, (j >= P) ? 1'b1 : 1'b0, "R8 full restart width");
    end

    // R9: abort a pulse, no resumption on re-enable
    cyc(1, 0, 0);
    cyc(0, 0, 1);
    almEnable = 0;
    cyc(0, 0, 0);
    chk(irqN, 1'b1, "R9 pulse aborted");
    almEnable = 1;
    cyc(0, 0, 0);
    chk(irqN, 1'b1, "R9 no resume");
    chk(almStatus, 1'b1, "R9 status kept int");

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule